// File: doc/BRIEF.md
# Redundant Configuration Shadow Loader

After every reset this block walks a fixed list of configuration word addresses, reads each word from nonvolatile storage through a synchronous read port, and writes it into volatile shadow registers. The list covers a general-purpose region of four words and a security region of four words. Both regions sit on a 0x10 word-address stride. Each word is read with one request, and the next request waits until the previous response has arrived. Single-bit errors are corrected inside the read port and never reach the loader. An uncorrectable (double-bit) error flag on any response makes the loader throw away everything loaded so far and start again from word 0 of a duplicate set, which sits a fixed 0x800 above the primary addresses. If the duplicate set also reports an uncorrectable error, the loader gives up and raises a fatal flag.

Every shadow word is stored twice: once as the loaded value and once as its bitwise complement. A checker compares the two copies on every cycle. The first pair found not to be complementary sets a sticky integrity flag. An upset port flips bits of a stored complement copy. It models a storage upset, so the continuous check can be exercised.

Top module: `cfg_shadow_loader`

## Requirements
- R1: From reset until the last word is written, `loadDone` is 0 and every bit of `shadowOut` reads 1.
- R2: Words are requested in index order. Index i < 4 reads address 0x7F3000 + 0x10·i, and index i ≥ 4 reads 0x7F4000 + 0x10·(i−4). Each word is requested exactly once per pass, and a request is never issued in the cycle after another request.
- R3: On a clean pass, `usedBackup` stays 0 and exactly eight reads are issued.
- R4: A response with `rdDbe` = 1 during the primary pass restarts the load at word 0 with 0x800 added to every address. `usedBackup` is then set and stays 1.
- R5: A response with `rdDbe` = 1 during the backup pass stops the load for good. `loadFatal` goes to 1, `loadDone` stays 0 and `shadowOut` stays all ones.
- R6: After the last word is written, `loadDone` is 1 and stays 1. Word i of `shadowOut` (bits 32·i+31 down to 32·i) then equals the data returned for index i on the pass that completed.
- R7: When a stored pair stops being complementary, `integrityErr` becomes 1 one cycle later and stays 1 until reset. An upset with an all-zero mask leaves it 0, and an upset never changes `shadowOut`.
- R8: Reset clears `loadDone`, `loadFatal`, `usedBackup` and `integrityErr` and runs the whole load again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdReq | output | 1 | Read request, one cycle per word |
| rdAddr | output | 24 | Word address of the request |
| rdValid | input | 1 | Response strobe from the read port |
| rdData | input | 32 | Corrected read data |
| rdDbe | input | 1 | Uncorrectable error on this response |
| upsetEn | input | 1 | Apply an upset to a stored complement copy |
| upsetSel | input | 3 | Index of the word to upset |
| upsetMask | input | 32 | Bits of the complement copy to flip |
| shadowOut | output | 256 | Eight shadow words, word 0 in the low bits |
| loadDone | output | 1 | Load completed |
| usedBackup | output | 1 | Load switched to the duplicate set |
| loadFatal | output | 1 | Both sets failed |
| integrityErr | output | 1 | Sticky pair-mismatch flag |

## Verification
The hardest case to reach is the double failure. The primary pass has to break at one word and the backup pass at a different word. The fatal flag must then hold with the shadows still at all ones. The bench read-port model matches each response address against two programmable fault addresses. A fault address can name a primary word, a backup word, or both, so one reset reaches any switch point. The integrity flag cannot go up through a normal load, because both copies are written together. The bench therefore drives the upset port after a completed load, first with an empty mask and then with a single flipped bit.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef struct packed {
    logic writeWord;
    logic wipe;
  } ldStrobe_t;

  typedef enum logic [1:0] {
    ST_ISSUE = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DONE  = 2'd2,
    ST_FATAL = 2'd3
  } ldState_t;

endpackage

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int NUM_GEN = 4,
  parameter int NUM_SEC = 4,
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] GEN_BASE = 24'h7F3000,
  parameter logic [ADDR_W-1:0] SEC_BASE = 24'h7F4000,
  parameter logic [ADDR_W-1:0] STRIDE = 24'h10,
  parameter logic [ADDR_W-1:0] BACKUP_OFFSET = 24'h800,
  localparam int NUM_WORDS = NUM_GEN + NUM_SEC,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic              rdDbe,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output ldStrobe_t         strobe,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              loadDone,
  output logic              usedBackup,
  output logic              loadFatal
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
  localparam logic [IDX_W-1:0] GEN_LIMIT = IDX_W'(NUM_GEN);

  ldState_t state;
  logic onBackup;
  logic respOk;
  logic respBad;

  assign respOk  = (state == ST_WAIT) && rdValid && !rdDbe;
  assign respBad = (state == ST_WAIT) && rdValid && rdDbe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_ISSUE;
      wordIdx  <= '0;
      onBackup <= 1'b0;
    end else begin
      case (state)
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (respBad) begin
            if (onBackup) begin
              state <= ST_FATAL;
            end else begin
              onBackup <= 1'b1;
              wordIdx  <= '0;
              state    <= ST_ISSUE;
            end
          end else if (respOk) begin
            if (wordIdx == LAST_IDX) begin
              state <= ST_DONE;
            end else begin
              wordIdx <= wordIdx + 1'b1;
              state   <= ST_ISSUE;
            end
          end
        end
        default: state <= state;
      endcase
    end
  end

  // address of the current word: region base + slot * stride, lifted for backup
  logic [ADDR_W-1:0] regionBase;
  logic [ADDR_W-1:0] slot;
  always_comb begin
    if (wordIdx < GEN_LIMIT) begin
      regionBase = GEN_BASE;
      slot       = ADDR_W'(wordIdx);
    end else begin
      regionBase = SEC_BASE;
      slot       = ADDR_W'(wordIdx) - ADDR_W'(NUM_GEN);
    end
    rdAddr = regionBase + slot * STRIDE + (onBackup ? BACKUP_OFFSET : '0);
  end

  assign rdReq            = (state == ST_ISSUE);
  assign strobe.writeWord = respOk;
  assign strobe.wipe      = respBad;
  assign loadDone         = (state == ST_DONE);
  assign loadFatal        = (state == ST_FATAL);
  assign usedBackup       = onBackup;

endmodule

// File: rtl/cfgld_datapath.sv
module cfgld_datapath
  import cfgld_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ldStrobe_t                   strobe,
  input  logic [IDX_W-1:0]            wordIdx,
  input  logic [WORD_W-1:0]           rdData,
  input  logic                        upsetEn,
  input  logic [IDX_W-1:0]            upsetSel,
  input  logic [WORD_W-1:0]           upsetMask,
  input  logic                        loadDone,
  output logic [NUM_WORDS*WORD_W-1:0] shadowOut,
  output logic                        integrityErr
);

  logic [NUM_WORDS-1:0] mismatch;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] trueCopy;
    logic [WORD_W-1:0] compCopy;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        trueCopy <= '1;
        compCopy <= '0;
      end else if (strobe.wipe) begin
        trueCopy <= '1;
        compCopy <= '0;
      end else if (strobe.writeWord && wordIdx == IDX_W'(w)) begin
        trueCopy <= rdData;
        compCopy <= ~rdData;
      end else if (upsetEn && upsetSel == IDX_W'(w)) begin
        compCopy <= compCopy ^ upsetMask;
      end
    end

    assign mismatch[w] = ((trueCopy ^ compCopy) != '1);
    assign shadowOut[w*WORD_W +: WORD_W] = loadDone ? trueCopy : '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) integrityErr <= 1'b0;
    else if (|mismatch) integrityErr <= 1'b1;
  end

endmodule

// File: rtl/cfg_shadow_loader.sv
module cfg_shadow_loader
  import cfgld_pkg::*;
#(
  parameter int NUM_GEN = 4,
  parameter int NUM_SEC = 4,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] GEN_BASE = 24'h7F3000,
  parameter logic [ADDR_W-1:0] SEC_BASE = 24'h7F4000,
  parameter logic [ADDR_W-1:0] STRIDE = 24'h10,
  parameter logic [ADDR_W-1:0] BACKUP_OFFSET = 24'h800,
  localparam int NUM_WORDS = NUM_GEN + NUM_SEC,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  output logic                        rdReq,
  output logic [ADDR_W-1:0]           rdAddr,
  input  logic                        rdValid,
  input  logic [WORD_W-1:0]           rdData,
  input  logic                        rdDbe,
  input  logic                        upsetEn,
  input  logic [IDX_W-1:0]            upsetSel,
  input  logic [WORD_W-1:0]           upsetMask,
  output logic [NUM_WORDS*WORD_W-1:0] shadowOut,
  output logic                        loadDone,
  output logic                        usedBackup,
  output logic                        loadFatal,
  output logic                        integrityErr
);

  ldStrobe_t        strobe;
  logic [IDX_W-1:0] wordIdx;

  cfgld_ctrl #(
    .NUM_GEN(NUM_GEN), .NUM_SEC(NUM_SEC), .ADDR_W(ADDR_W),
    .GEN_BASE(GEN_BASE), .SEC_BASE(SEC_BASE), .STRIDE(STRIDE),
    .BACKUP_OFFSET(BACKUP_OFFSET)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .rdDbe(rdDbe),
    .rdReq(rdReq), .rdAddr(rdAddr), .strobe(strobe), .wordIdx(wordIdx),
    .loadDone(loadDone), .usedBackup(usedBackup), .loadFatal(loadFatal)
  );

  cfgld_datapath #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .rdData(rdData), .upsetEn(upsetEn), .upsetSel(upsetSel),
    .upsetMask(upsetMask), .loadDone(loadDone),
    .shadowOut(shadowOut), .integrityErr(integrityErr)
  );

endmodule

// File: rtl/cfg_shadow_loader_chk.sv
module cfg_shadow_loader_chk #(
  parameter int OUT_W = 256
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdReq,
  input logic             loadDone,
  input logic             loadFatal,
  input logic             usedBackup,
  input logic             integrityErr,
  input logic [OUT_W-1:0] shadowOut
);

  assert_safe_until_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    !loadDone |-> (shadowOut == {OUT_W{1'b1}}));

  assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  assert_backup_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    usedBackup |=> usedBackup);

  assert_fatal_after_backup_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadFatal |-> (usedBackup && !loadDone));

  assert_fatal_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadFatal |=> loadFatal);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> (loadDone && !rdReq));

  assert_integrity_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    integrityErr |=> integrityErr);

endmodule

bind cfg_shadow_loader cfg_shadow_loader_chk #(.OUT_W(NUM_WORDS * WORD_W)) i_chk (
  .clk(clk), .rstN(rstN), .rdReq(rdReq), .loadDone(loadDone),
  .loadFatal(loadFatal), .usedBackup(usedBackup),
  .integrityErr(integrityErr), .shadowOut(shadowOut)
);

// File: tb/test_cfg_shadow_loader.sv
module test_cfg_shadow_loader;

  localparam int CLK_PERIOD = 10;
  localparam int NWORDS = 8;
  localparam logic [23:0] NO_FAULT = 24'hFFFFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdReq;
  logic [23:0] rdAddr;
  logic rdValid;
  logic [31:0] rdData;
  logic rdDbe;
  logic upsetEn = 1'b0;
  logic [2:0] upsetSel = '0;
  logic [31:0] upsetMask = '0;
  logic [255:0] shadowOut;
  logic loadDone, usedBackup, loadFatal, integrityErr;

  int nChecks = 0;
  int nFails = 0;
  int reqCount = 0;
  logic [23:0] faultA = NO_FAULT;
  logic [23:0] faultB = NO_FAULT;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_shadow_loader i_cfg_shadow_loader (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .rdDbe(rdDbe),
    .upsetEn(upsetEn), .upsetSel(upsetSel), .upsetMask(upsetMask),
    .shadowOut(shadowOut), .loadDone(loadDone), .usedBackup(usedBackup),
    .loadFatal(loadFatal), .integrityErr(integrityErr)
  );

  function automatic logic [31:0] memWord(input logic [23:0] a);
    return {8'h3C, a} ^ 32'h00A5_5A00;
  endfunction

  function automatic logic [23:0] primAddr(input int i);
    if (i < 4) return 24'h7F3000 + 24'(i * 16);
    return 24'h7F4000 + 24'((i - 4) * 16);
  endfunction

  // read-port model: two-cycle latency
  logic p1, p2;
  logic [23:0] a1, a2;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p1 <= 1'b0; p2 <= 1'b0; a1 <= '0; a2 <= '0;
    end else begin
      p1 <= rdReq; a1 <= rdAddr;
      p2 <= p1;    a2 <= a1;
      if (rdReq) reqCount <= reqCount + 1;
    end
  end
  assign rdValid = p2;
  assign rdData  = memWord(a2);
  assign rdDbe   = p2 && (a2 == faultA || a2 == faultB);

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [23:0] fa, input logic [23:0] fb);
    @(negedge clk);
    rstN = 1'b0;
    faultA = fa;
    faultB = fb;
    repeat (3) @(negedge clk);
    reqCount = 0;
    rstN = 1'b1;
  endtask

  task automatic waitLoad();
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (loadDone || loadFatal) break;
    end
  endtask

  task automatic checkWords(input logic [23:0] offs, input string tag);
    for (int i = 0; i < NWORDS; i++) begin
      check(shadowOut[i*32 +: 32] == memWord(primAddr(i) + offs), tag,
            64'(shadowOut[i*32 +: 32]), 64'(memWord(primAddr(i) + offs)));
    end
  endtask

  task automatic testResetState();
    doReset(NO_FAULT, NO_FAULT);
    @(negedge clk);
    check(!loadDone, "R1 done low after reset", 64'(loadDone), 0);
    check(shadowOut == '1, "R1 shadow safe after reset", 64'(shadowOut[63:0]), 64'hFFFF_FFFF_FFFF_FFFF);
    check(!loadFatal && !usedBackup && !integrityErr, "R8 flags clear after reset",
          64'({loadFatal, usedBackup, integrityErr}), 0);
    repeat (12) @(negedge clk);
    check(!loadDone && shadowOut == '1, "R1 safe mid-load", 64'(loadDone), 0);
  endtask

  task automatic testCleanLoad();
    doReset(NO_FAULT, NO_FAULT);
    waitLoad();
    check(loadDone, "R6 done after clean load", 64'(loadDone), 1);
    check(!usedBackup, "R3 no backup on clean load", 64'(usedBackup), 0);
    check(reqCount == 8, "R3 eight reads", 64'(reqCount), 8);
    checkWords(24'h0, "R2 R6 primary word data");
    repeat (10) @(negedge clk);
    check(loadDone && reqCount == 8, "R6 done holds, no extra reads", 64'(reqCount), 8);
  endtask

  task automatic testBackupSwitch(input int badIdx);
    doReset(primAddr(badIdx), NO_FAULT);
    waitLoad();
    check(loadDone && !loadFatal, "R4 done via backup", 64'({loadDone, loadFatal}), 2);
    check(usedBackup, "R4 backup flag", 64'(usedBackup), 1);
    check(reqCount == badIdx + 1 + 8, "R4 restart from word 0",
          64'(reqCount), 64'(badIdx + 9));
    checkWords(24'h800, "R4 backup word data");
  endtask

  task automatic testFatal();
    doReset(primAddr(2), primAddr(6) + 24'h800);
    waitLoad();
    check(loadFatal, "R5 fatal set", 64'(loadFatal), 1);
    check(!loadDone, "R5 done stays low", 64'(loadDone), 0);
    check(reqCount == 3 + 7, "R5 reads stop at backup fault", 64'(reqCount), 10);
    repeat (20) @(negedge clk);
    check(loadFatal && !loadDone && shadowOut == '1, "R5 shadows safe after fatal",
          64'(shadowOut[63:0]), 64'hFFFF_FFFF_FFFF_FFFF);
    check(reqCount == 10, "R5 no further reads", 64'(reqCount), 10);
  endtask

  task automatic testIntegrity();
    doReset(NO_FAULT, NO_FAULT);
    waitLoad();
    check(!integrityErr, "R7 clean after load", 64'(integrityErr), 0);
    upsetEn = 1'b1; upsetSel = 3'd3; upsetMask = 32'h0;
    @(negedge clk);
    upsetEn = 1'b0;
    repeat (2) @(negedge clk);
    check(!integrityErr, "R7 empty mask no error", 64'(integrityErr), 0);
    upsetEn = 1'b1; upsetSel = 3'd3; upsetMask = 32'h0000_0400;
    @(negedge clk);
    upsetEn = 1'b0; upsetMask = 32'h0;
    @(negedge clk);
    check(integrityErr, "R7 mismatch flagged", 64'(integrityErr), 1);
    repeat (15) @(negedge clk);
    check(integrityErr, "R7 flag sticky", 64'(integrityErr), 1);
    checkWords(24'h0, "R7 shadow unchanged by upset");
  endtask

  task automatic testReloadClears();
    doReset(NO_FAULT, NO_FAULT);
    @(negedge clk);
    check(!integrityErr && !loadDone, "R8 reset clears integrity and done",
          64'({integrityErr, loadDone}), 0);
    waitLoad();
    check(loadDone && reqCount == 8, "R8 load reruns after reset", 64'(reqCount), 8);
    checkWords(24'h0, "R8 reloaded data");
  endtask

  initial begin
    testResetState();
    testCleanLoad();
    testBackupSwitch(5);
    testBackupSwitch(0);
    testBackupSwitch(7);
    testFatal();
    testIntegrity();
    testReloadClears();
    testFatal();
    testReloadClears();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule